// File: doc/BRIEF.md
# Dithered 14-bit PWM D-A Converter

The block turns a 14-bit code into a pulse train that, after external low-pass filtering, gives an analog level. It splits the latched code into an 8-bit coarse part and a 6-bit fine part. Every short period is 256 resolution units long, and its HIGH time is the coarse value in units. A frame is 64 short periods long. Within a frame, the fine part picks a subset of short periods, and each of those gets one extra unit of HIGH time. The mean duty cycle therefore moves in steps of 1/16384.

Software loads a new code in two writes: the coarse byte first, then the fine bits. The second write raises a pending flag. The staged code moves into the working latch at the start of the next short period, and the flag drops at that moment. The time base is the input clock divided by a parameter (two by default). A stop input freezes the time base. A polarity input inverts the pin, and a source-select input parks the pin low when the pin is not used for the converter.

Top module: `pwm14_dac`

## Requirements
- R1: While reset is asserted and after it is released, xfer_pending is 0 and the working code is 0, so dac_out is low with pol_inv=0 and out_sel=0.
- R2: One resolution unit lasts 2 clock cycles. A short period lasts 512 cycles, and in a short period that gets no extra unit dac_out is HIGH for 2*DH cycles at the start of the period, where DH is the coarse byte.
- R3: Short periods are numbered m = 0..63 within the frame. Fine bit j (j = 0..5) adds one unit to period m when the low 6-j bits of m are a 1 followed by 5-j zeros. Bit 5 therefore adds to every odd m, bit 0 adds only to m = 32, and m = 0 never gets an extra unit.
- R4: A short period is never fully HIGH: the HIGH time is min(DH + extra, 255) units, so coarse 255 with fine 63 gives 510 HIGH cycles in every period.
- R5: A wr_lo strobe stages wr_data[5:0]. The staged coarse and fine values take effect exactly at the next short-period boundary, where the cycle count since reset, excluding stopped cycles, is a multiple of 512.
- R6: xfer_pending rises on the cycle after a wr_lo strobe and stays 1 until the boundary load, after which it reads 0.
- R7: A wr_hi strobe on its own starts no transfer and does not change the output. A later wr_lo alone transfers the byte staged by that earlier wr_hi.
- R8: While cnt_stop=1, the time base, the waveform and dac_out are frozen, and a pending transfer stays pending.
- R9: With pol_inv=1, the HIGH time in each period is 512 minus the non-inverted HIGH time.
- R10: With out_sel=1, dac_out is held low.
- R11: wr_data bits 7:6 on a wr_lo strobe have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_hi | input | 1 | Strobe: stage wr_data as the coarse byte |
| wr_lo | input | 1 | Strobe: stage wr_data[5:0] as the fine bits and request a transfer |
| wr_data | input | 8 | Write data |
| xfer_pending | output | 1 | 1 while a requested transfer has not yet reached the latch |
| cnt_stop | input | 1 | 1 freezes the time base; 0 lets it run |
| pol_inv | input | 1 | 1 inverts the output level |
| out_sel | input | 1 | 0 routes the converter to the pin; 1 parks the pin low |
| dac_out | output | 1 | PWM output |

## Verification
The bench measures the HIGH time of every short period over two whole frames with a random fine value. It compares each period against the index mapping of R3, so a design that decodes the index bits the wrong way round, or that gives period 0 an extra unit, puts the extra unit in the wrong periods. Coarse 255 with fine 63 checks the saturation case: a design without the clamp would drive a fully HIGH period. The bench also checks that a transfer lands exactly on a period boundary, so a design that loads straight away would cut a period short. It checks that a coarse byte written alone starts nothing but is kept for the next fine write, and that stopping the count holds both the pin and the pending flag.

// File: rtl/pwm14_pkg.sv
package pwm14_pkg;
  localparam int COARSE_W_DEF = 8;
  localparam int FINE_W_DEF   = 6;
  localparam int CLK_DIV_DEF  = 2;

  typedef enum logic {
    SRC_DAC = 1'b0,
    SRC_OFF = 1'b1
  } out_src_e;
endpackage

// File: rtl/pwm14_prescale.sv
module pwm14_prescale #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;

  always_comb begin
    tick  = run && (div_q == LAST);
    div_d = div_q;
    if (run) div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwm14_regs.sv
module pwm14_regs #(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [CW-1:0] wr_data,
  input  logic          period_end,
  output logic [CW-1:0] coarse,
  output logic [FW-1:0] fine,
  output logic          pending
);
  logic [CW-1:0] stage_hi_q, stage_hi_d, coarse_q, coarse_d;
  logic [FW-1:0] stage_lo_q, stage_lo_d, fine_q, fine_d;
  logic          pend_q, pend_d, load;

  always_comb begin
    load       = pend_q && period_end;
    stage_hi_d = wr_hi ? wr_data : stage_hi_q;
    stage_lo_d = wr_lo ? wr_data[FW-1:0] : stage_lo_q;
    coarse_d   = load ? stage_hi_q : coarse_q;
    fine_d     = load ? stage_lo_q : fine_q;
    if (wr_lo)     pend_d = 1'b1;
    else if (load) pend_d = 1'b0;
    else           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi_q <= '0;
      stage_lo_q <= '0;
      coarse_q   <= '0;
      fine_q     <= '0;
      pend_q     <= 1'b0;
    end else begin
      stage_hi_q <= stage_hi_d;
      stage_lo_q <= stage_lo_d;
      coarse_q   <= coarse_d;
      fine_q     <= fine_d;
      pend_q     <= pend_d;
    end
  end

  assign coarse  = coarse_q;
  assign fine    = fine_q;
  assign pending = pend_q;

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && period_end) |=> ({coarse_q, fine_q} == $past({stage_hi_q, stage_lo_q})));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && period_end) |=> $stable({coarse_q, fine_q}));
  // R6
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && period_end && !wr_lo) |=> !pend_q);
  // R7
  hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !pend_q) |=> !pend_q);
endmodule

// File: rtl/pwm14_wave.sv
module pwm14_wave #(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] coarse,
  input  logic [FW-1:0] fine,
  output logic          period_end,
  output logic          wave
);
  localparam logic [CW-1:0] SEG_MAX = '1;

  logic [CW-1:0] seg_q, seg_d;
  logic [FW-1:0] frm_q, frm_d;
  logic [FW-1:0] hit;
  logic          extra;
  logic [CW:0]   width;

  // fine bit j matches a frame index whose low FW-j bits are 1 then zeros
  for (genvar j = 0; j < FW; j++) begin : g_fine
    localparam int L = FW - j;
    localparam logic [FW-1:0] PAT = FW'(1) << (L - 1);
    assign hit[j] = fine[j] && (frm_q[L-1:0] == PAT[L-1:0]);
  end

  always_comb begin
    period_end = tick && (seg_q == SEG_MAX);
    seg_d      = tick ? seg_q + 1'b1 : seg_q;
    frm_d      = period_end ? frm_q + 1'b1 : frm_q;
    extra      = |hit;
    width      = {1'b0, coarse} + {{CW{1'b0}}, extra};
    wave       = ({1'b0, seg_q} < width) && (seg_q != SEG_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      frm_q <= '0;
    end else begin
      seg_q <= seg_d;
      frm_q <= frm_d;
    end
  end

  // R4
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_MAX) |-> !wave);
  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(seg_q) && $stable(frm_q)));
endmodule

// File: rtl/pwm14_dac.sv
module pwm14_dac #(
  parameter int COARSE_W = pwm14_pkg::COARSE_W_DEF,
  parameter int FINE_W   = pwm14_pkg::FINE_W_DEF,
  parameter int CLK_DIV  = pwm14_pkg::CLK_DIV_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic [COARSE_W-1:0] wr_data,
  output logic                xfer_pending,
  input  logic                cnt_stop,
  input  logic                pol_inv,
  input  logic                out_sel,
  output logic                dac_out
);
  logic                tick, period_end, wave;
  logic [COARSE_W-1:0] coarse;
  logic [FINE_W-1:0]   fine;

  pwm14_prescale #(.DIV(CLK_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!cnt_stop),
    .tick (tick)
  );

  pwm14_regs #(.CW(COARSE_W), .FW(FINE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hi     (wr_hi),
    .wr_lo     (wr_lo),
    .wr_data   (wr_data),
    .period_end(period_end),
    .coarse    (coarse),
    .fine      (fine),
    .pending   (xfer_pending)
  );

  pwm14_wave #(.CW(COARSE_W), .FW(FINE_W)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .coarse    (coarse),
    .fine      (fine),
    .period_end(period_end),
    .wave      (wave)
  );

  always_comb begin
    if (out_sel == pwm14_pkg::SRC_OFF) dac_out = 1'b0;
    else                               dac_out = wave ^ pol_inv;
  end

  // R10
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sel |-> !dac_out);
endmodule

// File: tb/tb_pwm14_dac.sv
module tb_pwm14_dac;
  localparam int CLK_HALF = 2500;
  localparam int TAU     = 2;
  localparam int NSEG    = 256;
  localparam int PER     = TAU * NSEG;

  logic       clk = 1'b0;
  logic       rst_n, wr_hi, wr_lo, cnt_stop, pol_inv, out_sel;
  logic [7:0] wr_data;
  logic       xfer_pending, dac_out;

  int  runs = 0;
  int  checks = 0;
  int  fails = 0;
  int  cur_dh = 0;
  int  stg_dh = 0;
  int  cur_dl = 0;
  bit  done = 0;

  always #(CLK_HALF * 1ps) clk = ~clk;

  pwm14_dac dut (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .xfer_pending(xfer_pending), .cnt_stop(cnt_stop), .pol_inv(pol_inv),
    .out_sel(out_sel), .dac_out(dac_out)
  );

  always @(posedge clk) if (rst_n && !cnt_stop) runs <= runs + 1;

  function automatic int extra_of(int m, int dl);
    for (int j = 0; j < 6; j++)
      if (dl[j] && ((m & ((1 << (6 - j)) - 1)) == (1 << (5 - j)))) return 1;
    return 0;
  endfunction

  function automatic int exp_high(int m, int dh, int dl, bit pol, bit off);
    int w;
    w = dh + extra_of(m, dl);
    if (w > 255) w = 255;
    if (off) return 0;
    return pol ? PER - TAU * w : TAU * w;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic to_boundary();
    @(negedge clk);
    while ((runs % PER) != 0) @(negedge clk);
  endtask

  // starts at a period-start negedge; ends at a later one
  task automatic measure(int nper, string req);
    for (int p = 0; p < nper; p++) begin
      int m, cnt, e;
      m = (runs / PER) % 64;
      cnt = 0;
      for (int k = 0; k < PER; k++) begin
        if (dac_out) cnt++;
        @(negedge clk);
      end
      e = exp_high(m, cur_dh, cur_dl, pol_inv, out_sel);
      check(cnt == e, req, cnt, e);
    end
  endtask

  task automatic wait_load(string req);
    int n;
    n = 0;
    while (xfer_pending && n < 3 * PER) begin
      @(negedge clk);
      n++;
    end
    check(!xfer_pending, "R6 flag clears", xfer_pending, 0);
    check((runs % PER) == 0, req, runs % PER, 0);
    cur_dh = stg_dh;
  endtask

  task automatic load(int dh, int dl);
    @(negedge clk);
    wr_hi = 1'b1; wr_data = 8'(dh);
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b1; wr_data = {2'($urandom), 6'(dl)};
    @(negedge clk);
    wr_lo = 1'b0;
    stg_dh = dh;
    check(xfer_pending, "R6 flag set", xfer_pending, 1);
    wait_load("R5 load on boundary");
    cur_dl = dl;
  endtask

  initial begin
    void'($urandom(32'h1D0C));
    rst_n = 1'b0; wr_hi = 0; wr_lo = 0; wr_data = '0;
    cnt_stop = 0; pol_inv = 0; out_sel = 0;
    repeat (3) @(negedge clk);
    check(!xfer_pending, "R1 pending in reset", xfer_pending, 0);
    check(!dac_out, "R1 out in reset", dac_out, 0);
    rst_n = 1'b1;
    to_boundary();
    measure(1, "R1 idle after reset");

    load(100, 0);
    measure(4, "R2 coarse only");
    load(0, 0);
    measure(2, "R2 zero code");

    load(int'($urandom_range(1, 254)), int'($urandom_range(1, 62)));
    measure(128, "R3 fine spread over two frames");

    load(255, 63);
    measure(64, "R4 never fully high");

    // R11: upper bits on the fine write are set but ignored
    @(negedge clk);
    wr_hi = 1'b1; wr_data = 8'd37;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 8'hC0;
    @(negedge clk);
    wr_lo = 1'b0; stg_dh = 37;
    wait_load("R11 load on boundary");
    cur_dl = 0;
    measure(4, "R11 upper bits ignored");

    // R7: coarse byte alone
    @(negedge clk);
    wr_hi = 1'b1; wr_data = 8'd200;
    @(negedge clk);
    wr_hi = 1'b0;
    check(!xfer_pending, "R7 no transfer on high write", xfer_pending, 0);
    to_boundary();
    measure(2, "R7 output unchanged");
    check(!xfer_pending, "R7 still idle", xfer_pending, 0);
    @(negedge clk);
    wr_lo = 1'b1; wr_data = 8'd5;
    @(negedge clk);
    wr_lo = 1'b0; stg_dh = 200;
    wait_load("R7 load on boundary");
    cur_dl = 5;
    measure(3, "R7 staged high byte used");

    // R8: stop freezes pin and pending transfer
    repeat (100) @(negedge clk);
    cnt_stop = 1'b1;
    @(negedge clk);
    begin
      logic held;
      bit   moved, lost;
      held = dac_out;
      wr_lo = 1'b1; wr_data = 8'd33;
      @(negedge clk);
      wr_lo = 1'b0;
      moved = 0; lost = 0;
      for (int k = 0; k < 2 * PER; k++) begin
        if (dac_out !== held) moved = 1;
        if (!xfer_pending) lost = 1;
        @(negedge clk);
      end
      check(!moved, "R8 output frozen", moved, 0);
      check(!lost, "R8 transfer held", lost, 0);
    end
    cnt_stop = 1'b0;
    wait_load("R8 load after restart");
    cur_dl = 33;
    measure(2, "R8 resumes");

    // R9 polarity
    pol_inv = 1'b1;
    to_boundary();
    measure(3, "R9 inverted");
    pol_inv = 1'b0;

    // R10 parked output
    out_sel = 1'b1;
    to_boundary();
    measure(2, "R10 parked low");
    out_sel = 1'b0;

    // random mix
    for (int r = 0; r < 5; r++) begin
      load(int'($urandom_range(0, 255)), int'($urandom_range(0, 63)));
      measure(3, "R3 random code");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_HALF * 2 * 190000 * 1ps);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule